// File: doc/BRIEF.md
# Dual-Converter Serial Readout Interface

This block is the digital side of a simultaneous-sampling pair of 12-bit converters. It runs entirely on the serial clock and uses an active-low chip select. The falling SCLK edge that first sees chip select low marks the sampling instant. At that edge the block latches the channel-select and range controls, together with the selected channel's result from each converter core. The core results come in as plain input buses, which stand in for the converters.

Each converter's result leaves on its own serial line as a 16-bit frame. The frame is a leading zero, three status bits and the result, MSB first, with one bit per falling SCLK edge. If chip select stays low past the first frame, each line then carries the other converter's frame. A host with a single serial port can therefore collect both results from one line. The range control chooses straight binary or two's complement coding. It is looked at again partway through the frame, and a change seen there flips the output coding.

Top module: `dual_adc_serial_if`

## Requirements
- R1: A frame starts at the falling SCLK edge that first samples `cs_n` low after it was high. That edge latches `chan_sel`, `range_sel` and the selected results. Bit 0, a zero, is on both outputs after that edge.
- R2: Bit index k, counted from 0, is on the outputs after the k-th falling edge that follows the start edge. Frame bits are: 0 = zero, 1 = converter id (A = 0, B = 1), 2 = latched channel bit, 3 = latched range bit, 4..15 = result MSB first.
- R3: With the latched channel bit low, both converters report `*_ch1`. With it high, both report `*_ch2`. Changes on `chan_sel` or on the result buses after the start edge do not affect the frame in progress.
- R4: With the latched range bit low the result is straight binary. With it high the result is two's complement, formed by inverting the result MSB.
- R5: At the falling edge that advances the bit index to 8, the coding takes the level of `range_sel`. A changed level flips the coding of the result MSB sent later in the chained frame (bit index 20). The status range bit and the first frame's MSB keep the value latched at the start edge.
- R6: Bit indices 16..31 carry the other converter's frame: `sdo_a` carries B's frame (id 1) and `sdo_b` carries A's frame (id 0).
- R7: After bit index 31, both outputs stay 0 while `cs_n` remains low.
- R8: After any falling edge that samples `cs_n` high, both outputs are 0. This aborts a frame in progress, and the next start begins again at bit 0.
- R9: While `rst_n` is low and after release with `cs_n` high, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; frames the transfer |
| chan_sel | input | 1 | Channel pair select, latched at frame start |
| range_sel | input | 1 | Range/coding select, latched at start, rechecked at bit 8 |
| a_ch1 | input | RES_W | Converter A, channel 1 result |
| a_ch2 | input | RES_W | Converter A, channel 2 result |
| b_ch1 | input | RES_W | Converter B, channel 1 result |
| b_ch2 | input | RES_W | Converter B, channel 2 result |
| sdo_a | output | 1 | Serial data line A |
| sdo_b | output | 1 | Serial data line B |

## Verification
The bench uses the default parameters: 12-bit results and a recheck at bit index 8. At these values a full chained transfer is 32 bits. It is short enough to run every combination of latched channel and range, with and without a mid-frame range change. It also covers transfers that end early, at exactly 16 bits and past 32 bits. The result values include all-ones, MSB-only and zero, so the MSB inversion of two's complement coding is visible in both frames.

// File: rtl/dual_adc_serial_if.sv
module dual_adc_serial_if #(
  parameter int RES_W       = 12,
  parameter int RECHECK_IDX = 8
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             chan_sel,
  input  logic             range_sel,
  input  logic [RES_W-1:0] a_ch1,
  input  logic [RES_W-1:0] a_ch2,
  input  logic [RES_W-1:0] b_ch1,
  input  logic [RES_W-1:0] b_ch2,
  output logic             sdo_a,
  output logic             sdo_b
);
  localparam int FRAME_W = RES_W + 4;
  localparam int TOTAL   = 2 * FRAME_W;
  localparam int CW      = $clog2(TOTAL);
  localparam logic [CW-1:0] LAST    = CW'(TOTAL - 1);
  localparam logic [CW-1:0] RECHECK = CW'(RECHECK_IDX - 1);

  logic             cs_q, active, chan_l, rng_l, twos;
  logic [CW-1:0]    cnt;
  logic [RES_W-1:0] res_a, res_b;

  wire start = !cs_n && cs_q;

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      active <= 1'b0;
      cnt    <= '0;
      chan_l <= 1'b0;
      rng_l  <= 1'b0;
      twos   <= 1'b0;
      res_a  <= '0;
      res_b  <= '0;
    end else begin
      cs_q <= cs_n;
      if (cs_n) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (start) begin
        active <= 1'b1;
        cnt    <= '0;
        chan_l <= chan_sel;
        rng_l  <= range_sel;
        twos   <= range_sel;
        res_a  <= chan_sel ? a_ch2 : a_ch1;
        res_b  <= chan_sel ? b_ch2 : b_ch1;
      end else if (active) begin
        if (cnt == LAST) active <= 1'b0;
        else             cnt    <= cnt + 1'b1;
        if (cnt == RECHECK) twos <= range_sel;
      end
    end
  end

  wire [FRAME_W-1:0] frm_a = {1'b0, 1'b0, chan_l, rng_l, res_a[RES_W-1] ^ twos, res_a[RES_W-2:0]};
  wire [FRAME_W-1:0] frm_b = {1'b0, 1'b1, chan_l, rng_l, res_b[RES_W-1] ^ twos, res_b[RES_W-2:0]};
  wire [TOTAL-1:0]   str_a = {frm_a, frm_b};
  wire [TOTAL-1:0]   str_b = {frm_b, frm_a};
  wire [CW-1:0]      pos   = LAST - cnt;

  assign sdo_a = active & str_a[pos];
  assign sdo_b = active & str_b[pos];
endmodule

module dual_adc_serial_if_chk (
  input logic sclk,
  input logic rst_n,
  input logic cs_n,
  input logic chan_sel,
  input logic range_sel,
  input logic sdo_a,
  input logic sdo_b
);
  a_r8_idle_zero: assert property (@(negedge sclk) disable iff (!rst_n)
    cs_n |=> (!sdo_a && !sdo_b));

  a_r1_lead_zero: assert property (@(negedge sclk) disable iff (!rst_n)
    (!cs_n && $past(cs_n)) |=> (!sdo_a && !sdo_b));

  a_r2_conv_id: assert property (@(negedge sclk) disable iff (!rst_n)
    (!cs_n && $past(cs_n)) ##1 !cs_n |=> (!sdo_a && sdo_b));

  a_r2_chan_status: assert property (@(negedge sclk) disable iff (!rst_n)
    (!cs_n && $past(cs_n)) ##1 !cs_n ##1 !cs_n |=>
      (sdo_a == $past(chan_sel, 3) && sdo_b == $past(chan_sel, 3)));

  a_r2_range_status: assert property (@(negedge sclk) disable iff (!rst_n)
    (!cs_n && $past(cs_n)) ##1 !cs_n ##1 !cs_n ##1 !cs_n |=>
      (sdo_a == $past(range_sel, 4) && sdo_b == $past(range_sel, 4)));
endmodule

bind dual_adc_serial_if dual_adc_serial_if_chk u_chk (
  .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .chan_sel(chan_sel),
  .range_sel(range_sel), .sdo_a(sdo_a), .sdo_b(sdo_b)
);

// File: tb/dual_adc_serial_if_bench.sv
module dual_adc_serial_if_bench;
  logic sclk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic chan_sel = 1'b0;
  logic range_sel = 1'b0;
  logic [11:0] a_ch1 = '0, a_ch2 = '0, b_ch1 = '0, b_ch2 = '0;
  logic sdo_a, sdo_b;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [1:0] q_exp[$];
  string      q_tag[$];

  always #10 sclk = ~sclk;

  dual_adc_serial_if #(.RES_W(12), .RECHECK_IDX(8)) u_dual_adc_serial_if (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .chan_sel(chan_sel),
    .range_sel(range_sel), .a_ch1(a_ch1), .a_ch2(a_ch2), .b_ch1(b_ch1),
    .b_ch2(b_ch2), .sdo_a(sdo_a), .sdo_b(sdo_b)
  );

  function automatic logic [15:0] frm(input logic id, input logic ch, input logic rg,
                                      input logic tw, input logic [11:0] r);
    return {1'b0, id, ch, rg, r[11] ^ tw, r[10:0]};
  endfunction

  task automatic check(input logic [1:0] exp, input string tag);
    checks++;
    if ({sdo_a, sdo_b} !== exp) begin
      failures++;
      $display("FAIL %s: actual a=%b b=%b expected a=%b b=%b", tag, sdo_a, sdo_b, exp[1], exp[0]);
    end
  endtask

  always begin
    @(posedge sclk);
    #1;
    if (q_exp.size() > 0) check(q_exp.pop_front(), q_tag.pop_front());
  end

  task automatic run_frame(input logic ch, input logic rg, input logic rgm, input int nbits);
    logic [11:0] ra, rb;
    logic [31:0] sa, sb;
    string t;
    ra = ch ? a_ch2 : a_ch1;
    rb = ch ? b_ch2 : b_ch1;
    sa = {frm(1'b0, ch, rg, rg, ra), frm(1'b1, ch, rg, rgm, rb)};
    sb = {frm(1'b1, ch, rg, rg, rb), frm(1'b0, ch, rg, rgm, ra)};
    @(posedge sclk); #2;
    chan_sel = ch;
    range_sel = rg;
    cs_n = 1'b0;
    for (int k = 0; k < nbits; k++) begin
      if (k == 1) begin
        chan_sel = ~ch;       // R3: ignored after start
        range_sel = rgm;      // R5: seen at bit-8 edge
        a_ch1 = ~a_ch1; a_ch2 = ~a_ch2; b_ch1 = ~b_ch1; b_ch2 = ~b_ch2;
      end
      if (k == 0) t = "R1";
      else if (k < 4) t = "R2";
      else if (k == 4) t = "R4";
      else if (k == 20) t = "R5";
      else if (k >= 32) t = "R7";
      else if (k >= 16) t = "R6";
      else t = "R3";
      if (k < 32) q_exp.push_back({sa[31-k], sb[31-k]});
      else q_exp.push_back(2'b00);
      q_tag.push_back(t);
      @(posedge sclk); #2;
    end
    cs_n = 1'b1;
    a_ch1 = ~a_ch1; a_ch2 = ~a_ch2; b_ch1 = ~b_ch1; b_ch2 = ~b_ch2;
    for (int k = 0; k < 2; k++) begin
      q_exp.push_back(2'b00);
      q_tag.push_back("R8");
      @(posedge sclk); #2;
    end
  endtask

  initial begin
    repeat (3) @(posedge sclk);
    #1; check(2'b00, "R9");
    #2; rst_n = 1'b1;
    repeat (3) @(posedge sclk);
    #1; check(2'b00, "R9");
    a_ch1 = 12'hA5C; a_ch2 = 12'h123; b_ch1 = 12'h3F0; b_ch2 = 12'hFFF;
    run_frame(1'b0, 1'b0, 1'b0, 32);
    run_frame(1'b1, 1'b1, 1'b1, 32);
    run_frame(1'b0, 1'b1, 1'b0, 32);   // R5 flip to binary
    run_frame(1'b1, 1'b0, 1'b1, 36);   // R5 flip to twos, R7 tail
    run_frame(1'b1, 1'b1, 1'b1, 7);    // R8 abort
    run_frame(1'b1, 1'b0, 1'b0, 16);
    a_ch1 = 12'h800; a_ch2 = 12'h000; b_ch1 = 12'h7FF; b_ch2 = 12'h001;
    run_frame(1'b0, 1'b1, 1'b1, 32);
    run_frame(1'b1, 1'b0, 1'b0, 33);
    wait (q_exp.size() == 0);
    @(posedge sclk); #3;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule